// File: doc/BRIEF.md
# Register-Mapped Serial Port with Transmit and Receive Queues

This block is an asynchronous serial port that software drives through four word-aligned 32-bit registers on a plain address/strobe bus. Bytes written to the transmit data register are queued in an 8-entry transmit FIFO. A transmitter state machine sends each byte as a frame of one start bit, eight data bits with the least significant bit first, and one stop bit. A receiver state machine watches the serial input, confirms the start bit at its midpoint, and samples each data bit at its centre. Received bytes are queued in an 8-entry receive FIFO, from which software pops them by reading the receive data register.

Register map, by byte offset. Offset 0x0 is control. Offset 0x4 is status, which is read-only. Offset 0x8 is transmit data, write-only. Offset 0xC is receive data, read-only. Reads are combinational in the cycle that `rd_en` is high. A write takes effect at the clock edge that samples `wr_en`. The interrupt output combines a "transmit queue empty" source and a "receive queue holds data" source, and each source has its own enable bit.

The transmitter machine has four states. TX_IDLE goes to TX_START when sending is enabled and the queue is not empty, popping the head entry. TX_START goes to TX_DATA after one bit period. TX_DATA goes to TX_STOP after the eighth data bit. TX_STOP goes back to TX_IDLE after one bit period. The receiver machine also has four states. RX_IDLE goes to RX_START on a low synchronised line while receiving is enabled. RX_START goes to RX_DATA if the line is still low at half a bit period, and otherwise returns to RX_IDLE. RX_DATA goes to RX_STOP after eight samples. RX_STOP goes to RX_IDLE one bit period later, pushing the byte if the stop bit is high. Clearing the receive enable sends any receiver state back to RX_IDLE.

Top module: `serial_port`

## Requirements
- R1: After reset, control reads 0x00D90000, status reads 0x0000003C, and `irq_o` is 0.
- R2: Control bits 0 (transmit enable), 1 (receive enable), 2 (transmit-empty interrupt enable), 3 (receive-data interrupt enable) and 31:16 (divider) read back as written. All other control bits read 0.
- R3: Writing control with bit 4 set empties the transmit FIFO, and with bit 5 set empties the receive FIFO, at that write's clock edge.
- R4: Status bit 0 is transmit FIFO full, bit 1 is receive FIFO full, bit 2 is transmit FIFO empty, bit 3 is receive FIFO empty, and bit 5 is receiver idle. The upper bits read 0.
- R5: Status bit 4 (transmitter idle) is 1 only when the transmit FIFO is empty and the last stop bit has finished. It reads 0 while a frame is still shifting out of an empty queue.
- R6: Each frame is one low start bit, eight data bits sent LSB first, and one high stop bit. Every bit lasts divider+1 clock cycles.
- R7: The receiver queues each correctly framed byte. A read of receive data returns the oldest byte in bits 7:0 and pops it. A read while the receive FIFO is empty returns 0 and changes nothing.
- R8: Each FIFO holds 8 bytes. A write to a full transmit FIFO is dropped, and a byte received while the receive FIFO is full is discarded.
- R9: With transmit enable at 0, no new frame starts and the line stays high. With receive enable at 0, the serial input is ignored. Neither enable changes queued bytes.
- R10: `irq_o` is 1 exactly when (transmit FIFO empty and bit 2 set) or (receive FIFO not empty and bit 3 set).
- R11: A software push into the transmit FIFO in the same cycle that the transmitter pops it keeps both operations. No byte is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Byte address of the register |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while `rd_en` is high |
| rx_i | input | 1 | Serial input |
| tx_o | output | 1 | Serial output, idle high |
| irq_o | output | 1 | Interrupt request |

## Verification
The collision that matters is a software push into the transmit FIFO in the same cycle that the transmitter machine leaves TX_IDLE and pops the head entry. The bench provokes it by enabling the transmitter with an empty queue and then writing three bytes on consecutive cycles, so the second write meets the first pop. The serial line is decoded concurrently, and the collision is judged by the exact order and count of the frames and by the queue reading empty afterwards. A loopback sweep over all 256 byte values also overlaps receiver pushes with register traffic on the status and data registers.

// File: rtl/serial_port_pkg.sv
package serial_port_pkg;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    typedef enum logic [1:0] {
        SEL_CTRL,
        SEL_STAT,
        SEL_TXD,
        SEL_RXD
    } reg_sel_e;

    localparam int CTRL_TX_CLR_BIT = 4;
    localparam int CTRL_RX_CLR_BIT = 5;
    localparam int CTRL_DIV_LSB    = 16;

endpackage

// File: rtl/serial_fifo.sv
module serial_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [AW-1:0]    wp_q, rp_q;
    logic [CW-1:0]    cnt_q;
    logic             do_push, do_pop;

    function automatic logic [AW-1:0] advance(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem_q[rp_q];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else if (clr) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= advance(wp_q);
            if (do_pop)  rp_q <= advance(rp_q);
            if (do_push && !do_pop)      cnt_q <= cnt_q + CW'(1);
            else if (do_pop && !do_push) cnt_q <= cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem_q[wp_q] <= wdata;
    end

endmodule

// File: rtl/serial_tx.sv
module serial_tx
    import serial_port_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [DIV_W-1:0]  div,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_data,
    output logic              fifo_pop,
    output logic              line_o,
    output logic              busy
);
    localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    tx_state_e         state_q, state_d;
    logic [DIV_W-1:0]  cnt_q;
    logic [BW-1:0]     bit_q;
    logic [DATA_W-1:0] shift_q;
    logic              bit_end, last_bit, start_ok;

    assign bit_end  = (cnt_q == div);
    assign last_bit = (bit_q == BW'(DATA_W - 1));
    assign start_ok = enable && !fifo_empty;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (start_ok)             state_d = TX_START;
            TX_START: if (bit_end)              state_d = TX_DATA;
            TX_DATA:  if (bit_end && last_bit)  state_d = TX_STOP;
            TX_STOP:  if (bit_end)              state_d = TX_IDLE;
            default:                            state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
            shift_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == TX_IDLE || bit_end) cnt_q <= '0;
            else                               cnt_q <= cnt_q + DIV_W'(1);
            if (state_q == TX_IDLE && start_ok)
                shift_q <= fifo_data;
            else if (state_q == TX_DATA && bit_end)
                shift_q <= shift_q >> 1;
            if (state_q != TX_DATA) bit_q <= '0;
            else if (bit_end)       bit_q <= bit_q + BW'(1);
        end
    end

    always_comb begin
        fifo_pop = 1'b0;
        line_o   = 1'b1;
        busy     = 1'b1;
        unique case (state_q)
            TX_IDLE: begin
                busy     = 1'b0;
                fifo_pop = start_ok;
            end
            TX_START: line_o = 1'b0;
            TX_DATA:  line_o = shift_q[0];
            TX_STOP:  line_o = 1'b1;
            default:  busy   = 1'b0;
        endcase
    end

endmodule

// File: rtl/serial_rx.sv
module serial_rx
    import serial_port_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [DIV_W-1:0]  div,
    input  logic              line_i,
    output logic              push,
    output logic [DATA_W-1:0] data,
    output logic              idle
);
    localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    rx_state_e         state_q, state_d;
    logic [1:0]        sync_q;
    logic [DIV_W-1:0]  cnt_q;
    logic [BW-1:0]     bit_q;
    logic [DATA_W-1:0] shift_q;
    logic              rx_s, bit_end, mid_start, last_bit;

    assign rx_s      = sync_q[1];
    assign bit_end   = (cnt_q == div);
    assign mid_start = (cnt_q == (div >> 1));
    assign last_bit  = (bit_q == BW'(DATA_W - 1));
    assign data      = shift_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (enable && !rx_s) state_d = RX_START;
            RX_START: begin
                if (!enable)        state_d = RX_IDLE;
                else if (mid_start) state_d = rx_s ? RX_IDLE : RX_DATA;
            end
            RX_DATA: begin
                if (!enable)                   state_d = RX_IDLE;
                else if (bit_end && last_bit)  state_d = RX_STOP;
            end
            RX_STOP: begin
                if (!enable || bit_end) state_d = RX_IDLE;
            end
            default: state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            sync_q  <= 2'b11;
            cnt_q   <= '0;
            bit_q   <= '0;
            shift_q <= '0;
        end else begin
            state_q <= state_d;
            sync_q  <= {sync_q[0], line_i};
            if (state_q == RX_IDLE || bit_end || (state_q == RX_START && mid_start))
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + DIV_W'(1);
            if (state_q == RX_DATA && bit_end)
                shift_q <= {rx_s, shift_q[DATA_W-1:1]};
            if (state_q != RX_DATA) bit_q <= '0;
            else if (bit_end)       bit_q <= bit_q + BW'(1);
        end
    end

    always_comb begin
        push = 1'b0;
        idle = 1'b0;
        unique case (state_q)
            RX_IDLE:  idle = 1'b1;
            RX_START: push = 1'b0;
            RX_DATA:  push = 1'b0;
            RX_STOP:  push = enable && bit_end && rx_s;
            default:  idle = 1'b1;
        endcase
    end

endmodule

// File: rtl/serial_port.sv
module serial_port
    import serial_port_pkg::*;
#(
    parameter int          ADDR_W     = 4,
    parameter int          DATA_W     = 8,
    parameter int          FIFO_DEPTH = 8,
    parameter int          DIV_W      = 16,
    parameter logic [15:0] DIV_RESET  = 16'h00D9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              rx_i,
    output logic              tx_o,
    output logic              irq_o
);
    localparam int DIV_MSB = CTRL_DIV_LSB + DIV_W - 1;

    reg_sel_e          sel;
    logic              tx_en_q, rx_en_q, tx_ie_q, rx_ie_q;
    logic [DIV_W-1:0]  div_q;
    logic              ctrl_wr, tx_clr, rx_clr, tx_push, rx_pop;
    logic              tx_full, tx_empty, tx_pop, tx_busy, tx_idle;
    logic              rx_full, rx_empty, rx_push, rx_idle;
    logic [DATA_W-1:0] tx_head, rx_head, rx_byte;
    logic [31:0]       ctrl_view, stat_view;

    assign sel     = reg_sel_e'(addr[3:2]);
    assign ctrl_wr = wr_en && (sel == SEL_CTRL);
    assign tx_clr  = ctrl_wr && wdata[CTRL_TX_CLR_BIT];
    assign rx_clr  = ctrl_wr && wdata[CTRL_RX_CLR_BIT];
    assign tx_push = wr_en && (sel == SEL_TXD);
    assign rx_pop  = rd_en && (sel == SEL_RXD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_en_q <= 1'b0;
            rx_en_q <= 1'b0;
            tx_ie_q <= 1'b0;
            rx_ie_q <= 1'b0;
            div_q   <= DIV_W'(DIV_RESET);
        end else if (ctrl_wr) begin
            tx_en_q <= wdata[0];
            rx_en_q <= wdata[1];
            tx_ie_q <= wdata[2];
            rx_ie_q <= wdata[3];
            div_q   <= wdata[DIV_MSB:CTRL_DIV_LSB];
        end
    end

    serial_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tx_clr),
        .push  (tx_push),
        .wdata (wdata[DATA_W-1:0]),
        .pop   (tx_pop),
        .rdata (tx_head),
        .full  (tx_full),
        .empty (tx_empty)
    );

    serial_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rx_clr),
        .push  (rx_push),
        .wdata (rx_byte),
        .pop   (rx_pop),
        .rdata (rx_head),
        .full  (rx_full),
        .empty (rx_empty)
    );

    serial_tx #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (tx_en_q),
        .div        (div_q),
        .fifo_empty (tx_empty),
        .fifo_data  (tx_head),
        .fifo_pop   (tx_pop),
        .line_o     (tx_o),
        .busy       (tx_busy)
    );

    serial_rx #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (rx_en_q),
        .div    (div_q),
        .line_i (rx_i),
        .push   (rx_push),
        .data   (rx_byte),
        .idle   (rx_idle)
    );

    assign tx_idle = tx_empty && !tx_busy;

    always_comb begin
        ctrl_view = '0;
        ctrl_view[DIV_MSB:CTRL_DIV_LSB] = div_q;
        ctrl_view[3:0] = {rx_ie_q, tx_ie_q, rx_en_q, tx_en_q};
        stat_view = '0;
        stat_view[5:0] = {rx_idle, tx_idle, rx_empty, tx_empty, rx_full, tx_full};
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_CTRL: rdata = ctrl_view;
                SEL_STAT: rdata = stat_view;
                SEL_TXD:  rdata = '0;
                SEL_RXD:  rdata = rx_empty ? '0 : 32'(rx_head);
                default:  rdata = '0;
            endcase
        end
    end

    assign irq_o = (tx_ie_q && tx_empty) || (rx_ie_q && !rx_empty);

endmodule

// File: rtl/serial_port_chk.sv
module serial_port_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata,
    input logic              tx_o,
    input logic              irq_o,
    input logic              tx_en,
    input logic              tx_full,
    input logic              tx_empty,
    input logic              tx_idle,
    input logic              rx_full,
    input logic              rx_empty
);
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_full && tx_empty) && !(rx_full && rx_empty)); // R4

    AST_IDLE_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> tx_empty); // R5

    AST_TX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[3:2] == 2'd0 && wdata[4]) |=> tx_empty); // R3

    AST_RX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[3:2] == 2'd0 && wdata[5]) |=> rx_empty); // R3

    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr[3:2] == 2'd3 && rx_empty) |-> (rdata == 32'd0)); // R7

    AST_START_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_o) |-> $past(tx_en)); // R9

    AST_QUIET_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && tx_idle) |=> tx_o); // R9

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (tx_empty || !rx_empty)); // R10

endmodule

bind serial_port serial_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wdata    (wdata),
    .rdata    (rdata),
    .tx_o     (tx_o),
    .irq_o    (irq_o),
    .tx_en    (tx_en_q),
    .tx_full  (tx_full),
    .tx_empty (tx_empty),
    .tx_idle  (tx_idle),
    .rx_full  (rx_full),
    .rx_empty (rx_empty)
);

// File: tb/serial_port_test.sv
module serial_port_test;
    localparam int DIV = 3;
    localparam int P   = DIV + 1;
    localparam logic [3:0] A_CTRL = 4'h0, A_STAT = 4'h4, A_TXD = 4'h8, A_RXD = 4'hC;
    localparam logic [31:0] DIVF = 32'(DIV) << 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rx_drv = 1'b1, loop = 1'b0;
    logic        rx_i, tx_o, irq_o;
    int          n_run = 0, n_fail = 0;

    assign rx_i = loop ? tx_o : rx_drv;

    always #4 clk = ~clk;

    serial_port uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .rx_i(rx_i), .tx_o(tx_o), .irq_o(irq_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        check(act === exp, req, act, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; loop = 1'b0; rx_drv = 1'b1;
        wr_en = 1'b0; rd_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_rx(output bit got);
        logic [31:0] s;
        got = 1'b0;
        for (int i = 0; i < 400; i++) begin
            rd(A_STAT, s);
            if (!s[3]) begin got = 1'b1; break; end
        end
    endtask

    task automatic get_frame(output logic [7:0] b, output bit ok);
        int guard = 0;
        bit start_low, stop_high;
        b = '0;
        while (tx_o !== 1'b0 && guard < 4000) begin
            @(negedge clk);
            guard++;
        end
        repeat (P / 2) @(negedge clk);
        start_low = (tx_o == 1'b0);
        for (int i = 0; i < 8; i++) begin
            repeat (P) @(negedge clk);
            b[i] = tx_o;
        end
        repeat (P) @(negedge clk);
        stop_high = (tx_o == 1'b1);
        ok = start_low && stop_high && (guard < 4000);
    endtask

    task automatic send_frame(input logic [7:0] b);
        @(negedge clk);
        rx_drv = 1'b0;
        repeat (P) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_drv = b[i];
            repeat (P) @(negedge clk);
        end
        rx_drv = 1'b1;
        repeat (2 * P) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [7:0]  fb;
        bit          ok, got;
        int          lowcnt;

        do_reset();

        // R1: reset values
        rd(A_CTRL, d); chk_eq("R1 ctrl reset", d, 32'h00D9_0000);
        rd(A_STAT, d); chk_eq("R1 status reset", d, 32'h0000_003C);
        chk_eq("R1 irq reset", 32'(irq_o), 32'd0);
        // R7: empty read gives zero
        rd(A_RXD, d); chk_eq("R7 empty read", d, 32'd0);

        // R2: control read-back, R10 transmit-empty source
        wr(A_CTRL, 32'h1234_FFFF);
        rd(A_CTRL, d); chk_eq("R2 ctrl readback", d, 32'h1234_000F);
        chk_eq("R10 tx empty irq", 32'(irq_o), 32'd1);
        wr(A_CTRL, DIVF | 32'h8);
        chk_eq("R10 rx ie without data", 32'(irq_o), 32'd0);

        // R6: bit period for two divider values
        for (int k = 0; k < 2; k++) begin
            automatic int dv = (k == 0) ? DIV : 6;
            do_reset();
            wr(A_CTRL, (32'(dv) << 16) | 32'h1);
            wr(A_TXD, 32'hFF);
            lowcnt = 0;
            for (int i = 0; i < 60; i++) begin
                @(negedge clk);
                if (tx_o == 1'b0) lowcnt++;
            end
            chk_eq("R6 start bit length", 32'(lowcnt), 32'(dv + 1));
        end

        // R6 / R7: loopback sweep over all byte values
        do_reset();
        loop = 1'b1;
        wr(A_CTRL, DIVF | 32'h3);
        for (int v = 0; v < 256; v++) begin
            wr(A_TXD, 32'(v));
            wait_rx(got);
            rd(A_RXD, d);
            check(got && d == 32'(v), "R6 R7 loopback byte", d, 32'(v));
        end
        loop = 1'b0;

        // R6 / R5: direct decode and idle flag timing
        do_reset();
        wr(A_CTRL, DIVF | 32'h1);
        fork
            begin
                get_frame(fb, ok);
                check(ok && fb == 8'hA5, "R6 decoded frame", 32'(fb), 32'hA5);
                rd(A_STAT, d); chk_eq("R5 idle low in stop bit", 32'(d[4]), 32'd0);
                repeat (P) @(negedge clk);
                rd(A_STAT, d); chk_eq("R5 idle after stop", 32'(d[4]), 32'd1);
            end
            begin
                wr(A_TXD, 32'hA5);
                repeat (3) @(negedge clk);
                rd(A_STAT, d);
                chk_eq("R5 empty but busy", {30'd0, d[4], d[2]}, 32'b01);
            end
        join

        // R8 / R9: fill while disabled, overflow dropped, then drain
        do_reset();
        wr(A_CTRL, DIVF);
        for (int i = 0; i < 9; i++) wr(A_TXD, 32'h40 + 32'(i));
        rd(A_STAT, d); chk_eq("R8 R4 tx full flags", d & 32'h15, 32'h01);
        chk_eq("R9 line high disabled", 32'(tx_o), 32'd1);
        wr(A_CTRL, DIVF | 32'h1);
        for (int i = 0; i < 8; i++) begin
            get_frame(fb, ok);
            check(ok && fb == 8'(8'h40 + i), "R8 R9 drained order", 32'(fb), 32'h40 + 32'(i));
        end
        lowcnt = 0;
        for (int i = 0; i < 4 * P; i++) begin
            @(negedge clk);
            if (tx_o == 1'b0) lowcnt++;
        end
        chk_eq("R8 overflow byte dropped", 32'(lowcnt), 32'd0);
        rd(A_STAT, d); chk_eq("R4 status drained", d, 32'h0000_003C);

        // R3: transmit queue clear, then no frame on enable
        do_reset();
        wr(A_CTRL, DIVF);
        wr(A_TXD, 32'h11);
        wr(A_TXD, 32'h22);
        rd(A_STAT, d); chk_eq("R3 tx not empty", 32'(d[2]), 32'd0);
        wr(A_CTRL, DIVF | 32'h10);
        rd(A_STAT, d); chk_eq("R3 tx cleared", 32'(d[2]), 32'd1);
        rd(A_CTRL, d); chk_eq("R3 pulse reads zero", d & 32'h30, 32'd0);
        wr(A_CTRL, DIVF | 32'h1);
        lowcnt = 0;
        for (int i = 0; i < 4 * P; i++) begin
            @(negedge clk);
            if (tx_o == 1'b0) lowcnt++;
        end
        chk_eq("R3 nothing sent", 32'(lowcnt), 32'd0);

        // R9: receiver disabled ignores line
        do_reset();
        wr(A_CTRL, DIVF);
        send_frame(8'h5A);
        rd(A_STAT, d); chk_eq("R9 rx disabled", d & 32'h28, 32'h28);

        // R8 / R4 / R10: receive overflow
        wr(A_CTRL, DIVF | 32'hA);
        chk_eq("R10 no rx data irq", 32'(irq_o), 32'd0);
        for (int i = 0; i < 9; i++) send_frame(8'hC0 + 8'(i));
        chk_eq("R10 rx data irq", 32'(irq_o), 32'd1);
        rd(A_STAT, d); chk_eq("R4 rx full flags", d & 32'h0A, 32'h02);
        for (int i = 0; i < 8; i++) begin
            rd(A_RXD, d);
            chk_eq("R7 R8 rx order", d, 32'hC0 + 32'(i));
        end
        rd(A_RXD, d); chk_eq("R8 rx overflow discarded", d, 32'd0);
        chk_eq("R10 irq cleared", 32'(irq_o), 32'd0);

        // R3: receive queue clear
        send_frame(8'h77);
        rd(A_STAT, d); chk_eq("R3 rx has data", 32'(d[3]), 32'd0);
        wr(A_CTRL, DIVF | 32'h22);
        rd(A_STAT, d); chk_eq("R3 rx cleared", 32'(d[3]), 32'd1);

        // R11: push and pop in the same cycle
        do_reset();
        wr(A_CTRL, DIVF | 32'h1);
        fork
            begin
                @(negedge clk);
                addr = A_TXD; wr_en = 1'b1; wdata = 32'h11;
                @(negedge clk); wdata = 32'h22;
                @(negedge clk); wdata = 32'h33;
                @(negedge clk); wr_en = 1'b0;
            end
            begin
                for (int i = 0; i < 3; i++) begin
                    get_frame(fb, ok);
                    check(ok && fb == 8'(8'h11 * (i + 1)), "R11 collision order", 32'(fb), 32'h11 * 32'(i + 1));
                end
            end
        join
        repeat (2 * P) @(negedge clk);
        rd(A_STAT, d); chk_eq("R11 queue empty after", d & 32'h15, 32'h14);

        finish_run();
    end

endmodule